// File: doc/BRIEF.md
# Receive Ring Buffer Controller

This block takes an incoming packet as a byte stream and stores it in a byte-addressed local buffer memory. The memory is treated as a circular ring of 256-byte pages. Host-programmed start and stop registers set the ring's bounds. A boundary register, written by the host, marks the page the host has not yet released. The block may never write into that page.

Each packet begins on a fresh page. Its payload starts at byte offset 4, and offsets 0 to 3 are left free for a header. Once the end strobe arrives, the length and status are known. The block then fills the header with four bytes: the status byte, the page where the following packet will start, and the stored length plus four, low byte first. It then advances its current-page register and pulses a stored indication.

Some packets are not kept:
- A packet that would run into the boundary page sets a sticky overwrite flag and is reported as missed.
- A packet that arrives while monitor mode is on is also reported as missed.
- A packet with bad status is dropped silently unless saving of bad packets is enabled. Its space is reused.

Top module: `rx_ring_store`

## Requirements
- R1: After reset, mem_we, pkt_stored, missed and ovw_flag are low. The ring defaults to start page 0x04 and stop page 0x08, with current page 0x04 and boundary 0x07.
- R2: Each payload byte accepted with rx_valid after rx_sop is written once, in arrival order. Writing starts at offset 4 of the current page, and mem_we rises one cycle after the byte is sampled.
- R3: After a byte is written at offset 255, writing continues at offset 0 of the following page. The page after stop-1 is the start page.
- R4: Four header bytes are written at offsets 0, 1, 2 and 3 of the packet's first page, one per cycle, in the four cycles after the end strobe is sampled. In order they are the status byte, the next-packet page, count bits 7:0 and count bits 15:8, where count = payload length + 4.
- R5: The next-packet page is the page after the last page holding payload. When the last byte landed exactly at offset 255, it is the page the write pointer has already moved to.
- R6: pkt_stored pulses for one cycle together with the write of header byte 3. The current page takes the next-packet value on that same edge, so the next packet starts there.
- R7: No payload byte is ever written into the boundary page. A byte that would go there sets ovw_flag, and the rest of the packet is discarded. missed then pulses one cycle after the end strobe, no header is written, and the current page is unchanged.
- R8: If the packet's first page or its next-packet page equals the boundary at the end strobe, the block writes no header. It sets ovw_flag, pulses missed and leaves the current page unchanged.
- R9: ovw_flag stays set until the host writes the boundary register. It is low from the cycle after that write.
- R10: With mode_monitor high at the start strobe, the packet writes nothing. missed pulses one cycle after the end strobe, and the current page is unchanged.
- R11: With rx_good low and keep_bad low, the block writes no header and produces neither pulse, and the next packet reuses the same page. With keep_bad high, a bad packet is stored like a good one. pkt_stored and missed are never high together.
- R12: Host writes use host_sel 0 for start page, 1 for stop page, 2 for boundary and 3 for current page. Each write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 start, 1 stop, 2 boundary, 3 current |
| host_wdata | input | 8 | Host write data (page number) |
| mode_monitor | input | 1 | Monitor mode: packets are checked but not stored |
| keep_bad | input | 1 | Store packets that end with bad status |
| rx_sop | input | 1 | Start-of-packet strobe |
| rx_valid | input | 1 | Payload byte valid |
| rx_data | input | 8 | Payload byte |
| rx_eop | input | 1 | End-of-packet strobe, carries status |
| rx_good | input | 1 | Packet status good, sampled with rx_eop |
| rx_status | input | 8 | Status byte copied into header byte 0 |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer memory byte address {page, offset} |
| mem_wdata | output | 8 | Buffer memory write data |
| pkt_stored | output | 1 | One-cycle pulse when a packet is fully stored |
| ovw_flag | output | 1 | Sticky overwrite indication |
| missed | output | 1 | One-cycle pulse for a packet that was not stored |

## Verification
Every output is registered, so payload writes appear one cycle after the byte is sampled. missed appears one cycle after the end strobe is sampled. The four header writes follow in the next four cycles, and pkt_stored coincides with the fourth. The bench samples at the falling edge and logs each memory write with the index of the rising edge that produced it. It then compares the header write cycles and the pulse cycles against the end-strobe edge plus these fixed offsets. Addresses and data are compared against a page/offset walk that the bench computes itself from the ring bounds.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } rxr_state_e;

  localparam int HDR_BYTES = 4;
  localparam int CNT_W     = 16;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STOP  = 2'd1;
  localparam logic [1:0] SEL_BND   = 2'd2;
  localparam logic [1:0] SEL_CURR  = 2'd3;
endpackage

// File: rtl/rxr_page_next.sv
module rxr_page_next #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] cur,
  input  logic [PW-1:0] ring_start,
  input  logic [PW-1:0] ring_stop,
  output logic [PW-1:0] nxt
);
  logic [PW-1:0] inc;
  assign inc = cur + 1'b1;
  // wrap back to the ring start when the stop page is reached
  assign nxt = (inc == ring_stop) ? ring_start : inc;
endmodule

// File: rtl/rxr_host_regs.sv
module rxr_host_regs
  import rxr_pkg::*;
#(
  parameter int PW = 8,
  parameter logic [PW-1:0] DEF_START = 8'h04,
  parameter logic [PW-1:0] DEF_STOP  = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [PW-1:0] host_wdata,
  input  logic          adv_en,
  input  logic [PW-1:0] adv_page,
  output logic [PW-1:0] ring_start,
  output logic [PW-1:0] ring_stop,
  output logic [PW-1:0] ring_bnd,
  output logic [PW-1:0] ring_curr,
  output logic          bnd_wr
);
  localparam logic [PW-1:0] DEF_BND = DEF_STOP - 1'b1;

  assign bnd_wr = host_we && (host_sel == SEL_BND);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_start <= DEF_START;
      ring_stop  <= DEF_STOP;
      ring_bnd   <= DEF_BND;
      ring_curr  <= DEF_START;
    end else begin
      if (host_we && host_sel == SEL_START) ring_start <= host_wdata;
      if (host_we && host_sel == SEL_STOP)  ring_stop  <= host_wdata;
      if (bnd_wr)                           ring_bnd   <= host_wdata;
      // the internal advance takes priority over a host write of the current page
      if (adv_en)                                ring_curr <= adv_page;
      else if (host_we && host_sel == SEL_CURR)  ring_curr <= host_wdata;
    end
  end

  assert_curr_adv_R6: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> ring_curr == $past(adv_page));

  assert_bnd_write_R12: assert property (@(posedge clk) disable iff (rst)
    bnd_wr |=> ring_bnd == $past(host_wdata));
endmodule

// File: rtl/rxr_store_fsm.sv
module rxr_store_fsm
  import rxr_pkg::*;
#(
  parameter int PW = 8,
  parameter int PAGE_BYTES = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    ring_start,
  input  logic [PW-1:0]    ring_stop,
  input  logic [PW-1:0]    ring_bnd,
  input  logic [PW-1:0]    ring_curr,
  input  logic             bnd_wr,
  input  logic             mode_monitor,
  input  logic             keep_bad,
  input  logic             rx_sop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_eop,
  input  logic             rx_good,
  input  logic [7:0]       rx_status,
  output logic             mem_we,
  output logic [PW+$clog2(PAGE_BYTES)-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             pkt_stored,
  output logic             ovw_flag,
  output logic             missed,
  output logic             adv_en,
  output logic [PW-1:0]    adv_page
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int AW = PW + OW;
  localparam logic [OW-1:0] OFS_LAST  = OW'(PAGE_BYTES - 1);
  localparam logic [OW-1:0] OFS_FIRST = OW'(HDR_BYTES);

  rxr_state_e       state;
  logic [PW-1:0]    wr_page, pkt_page, nxt_wr, end_page, next_q;
  logic [OW-1:0]    wr_ofs;
  logic [CNT_W-1:0] byte_cnt, total_q;
  logic [1:0]       hdr_idx;
  logic [7:0]       stat_q, hdr_byte;
  logic             data_wr_q;

  rxr_page_next #(.PW(PW)) u_step (
    .cur(wr_page), .ring_start(ring_start), .ring_stop(ring_stop), .nxt(nxt_wr)
  );

  // offset 0 means the pointer already moved past a completely filled page
  assign end_page = (wr_ofs == '0) ? wr_page : nxt_wr;

  always_comb begin
    case (hdr_idx)
      2'd0:    hdr_byte = stat_q;
      2'd1:    hdr_byte = 8'(next_q);
      2'd2:    hdr_byte = total_q[7:0];
      default: hdr_byte = total_q[15:8];
    endcase
  end

  assign adv_en   = (state == ST_HDR) && (hdr_idx == 2'd3);
  assign adv_page = next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      pkt_stored <= 1'b0;
      missed     <= 1'b0;
      ovw_flag   <= 1'b0;
      data_wr_q  <= 1'b0;
      wr_page    <= '0;
      pkt_page   <= '0;
      wr_ofs     <= '0;
      byte_cnt   <= '0;
      total_q    <= '0;
      stat_q     <= '0;
      next_q     <= '0;
      hdr_idx    <= '0;
    end else begin
      mem_we     <= 1'b0;
      pkt_stored <= 1'b0;
      missed     <= 1'b0;
      data_wr_q  <= 1'b0;
      if (bnd_wr) ovw_flag <= 1'b0;
      case (state)
        ST_IDLE: if (rx_sop) begin
          if (mode_monitor) begin
            state <= ST_DROP;
          end else begin
            state    <= ST_RECV;
            wr_page  <= ring_curr;
            pkt_page <= ring_curr;
            wr_ofs   <= OFS_FIRST;
            byte_cnt <= '0;
          end
        end
        ST_RECV: begin
          if (rx_eop) begin
            if (pkt_page == ring_bnd || end_page == ring_bnd) begin
              ovw_flag <= 1'b1;
              missed   <= 1'b1;
              state    <= ST_IDLE;
            end else if (!rx_good && !keep_bad) begin
              state <= ST_IDLE;
            end else begin
              stat_q  <= rx_status;
              next_q  <= end_page;
              total_q <= byte_cnt + CNT_W'(HDR_BYTES);
              hdr_idx <= 2'd0;
              state   <= ST_HDR;
            end
          end else if (rx_valid) begin
            if (wr_page == ring_bnd) begin
              ovw_flag <= 1'b1;
              state    <= ST_DROP;
            end else begin
              mem_we    <= 1'b1;
              data_wr_q <= 1'b1;
              mem_addr  <= {wr_page, wr_ofs};
              mem_wdata <= rx_data;
              wr_ofs    <= wr_ofs + 1'b1;
              byte_cnt  <= byte_cnt + 1'b1;
              if (wr_ofs == OFS_LAST) wr_page <= nxt_wr;
            end
          end
        end
        ST_DROP: if (rx_eop) begin
          missed <= 1'b1;
          state  <= ST_IDLE;
        end
        default: begin
          mem_we    <= 1'b1;
          mem_addr  <= {pkt_page, OW'(hdr_idx)};
          mem_wdata <= hdr_byte;
          hdr_idx   <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd3) begin
            pkt_stored <= 1'b1;
            state      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assert_no_bnd_write_R7: assert property (@(posedge clk) disable iff (rst)
    data_wr_q |-> (mem_we && mem_addr[AW-1:OW] != $past(ring_bnd)));

  assert_stored_with_hdr3_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_stored |-> (mem_we && mem_addr[OW-1:0] == OW'(3)));

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    !(pkt_stored && missed));

  assert_missed_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    missed |=> !missed);

  assert_ovw_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovw_flag && !bnd_wr) |=> ovw_flag);
endmodule

// File: rtl/rx_ring_store.sv
module rx_ring_store
  import rxr_pkg::*;
#(
  parameter int PW = 8,
  parameter int PAGE_BYTES = 256,
  parameter logic [PW-1:0] DEF_START = 8'h04,
  parameter logic [PW-1:0] DEF_STOP  = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [PW-1:0] host_wdata,
  input  logic          mode_monitor,
  input  logic          keep_bad,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_eop,
  input  logic          rx_good,
  input  logic [7:0]    rx_status,
  output logic          mem_we,
  output logic [PW+$clog2(PAGE_BYTES)-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          pkt_stored,
  output logic          ovw_flag,
  output logic          missed
);
  logic [PW-1:0] ring_start, ring_stop, ring_bnd, ring_curr, adv_page;
  logic          adv_en, bnd_wr;

  rxr_host_regs #(.PW(PW), .DEF_START(DEF_START), .DEF_STOP(DEF_STOP)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .adv_en(adv_en), .adv_page(adv_page),
    .ring_start(ring_start), .ring_stop(ring_stop), .ring_bnd(ring_bnd),
    .ring_curr(ring_curr), .bnd_wr(bnd_wr)
  );

  rxr_store_fsm #(.PW(PW), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
    .clk(clk), .rst(rst), .ring_start(ring_start), .ring_stop(ring_stop),
    .ring_bnd(ring_bnd), .ring_curr(ring_curr), .bnd_wr(bnd_wr),
    .mode_monitor(mode_monitor), .keep_bad(keep_bad), .rx_sop(rx_sop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
    .rx_status(rx_status), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pkt_stored(pkt_stored), .ovw_flag(ovw_flag),
    .missed(missed), .adv_en(adv_en), .adv_page(adv_page)
  );
endmodule

// File: tb/rx_ring_store_test.sv
module rx_ring_store_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, host_we = 1'b0, mode_monitor = 1'b0, keep_bad = 1'b0;
  logic [1:0] host_sel = '0;
  logic [7:0] host_wdata = '0, rx_data = '0, rx_status = '0;
  logic rx_sop = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0, rx_good = 1'b1;
  logic mem_we, pkt_stored, ovw_flag, missed;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;

  rx_ring_store uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .mode_monitor(mode_monitor), .keep_bad(keep_bad),
    .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
    .rx_good(rx_good), .rx_status(rx_status), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pkt_stored(pkt_stored),
    .ovw_flag(ovw_flag), .missed(missed)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] log_a [0:1023];
  logic [7:0]  log_d [0:1023];
  int          log_c [0:1023];
  int nlog = 0, n_stored = 0, n_missed = 0, stored_cyc = 0, missed_cyc = 0;
  int ring_lo = 4, ring_hi = 8;

  always @(negedge clk) if (!rst) begin
    if (mem_we) begin
      if (nlog < 1024) begin
        log_a[nlog] = mem_addr; log_d[nlog] = mem_wdata; log_c[nlog] = cyc;
      end
      nlog++;
    end
    if (pkt_stored) begin n_stored++; stored_cyc = cyc; end
    if (missed) begin n_missed++; missed_cyc = cyc; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int find(input int a);
    int r = -1;
    for (int i = 0; i < nlog && i < 1024; i++) if (log_a[i] == 16'(a)) r = i;
    return r;
  endfunction

  function automatic int rd(input int a);
    int k = find(a);
    return (k < 0) ? -1 : int'(log_d[k]);
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 7 + (i >> 8));
  endfunction

  task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic setup(input int st, input int sp, input int bnd, input int cur);
    hwr(2'd0, 8'(st)); hwr(2'd1, 8'(sp)); hwr(2'd2, 8'(bnd)); hwr(2'd3, 8'(cur));
    ring_lo = st; ring_hi = sp;
    @(negedge clk);
  endtask

  // drives one packet; e returns the edge index at which the end strobe is sampled
  task automatic send(input int n, input int seed, input logic [7:0] st,
                      input logic good, output int e);
    @(negedge clk);
    nlog = 0; n_stored = 0; n_missed = 0; stored_cyc = -1; missed_cyc = -1;
    rx_sop = 1'b1;
    @(negedge clk); rx_sop = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = pat(seed, i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eop = 1'b1; rx_status = st; rx_good = good;
    e = cyc + 1;
    @(negedge clk); rx_eop = 1'b0; rx_good = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // payload placement walk computed from the ring bounds; returns mismatches
  function automatic int payload_errs(input int page, input int n, input int seed);
    int p = page, o = 4, errs = 0;
    for (int i = 0; i < n; i++) begin
      if (rd(p * 256 + o) != int'(pat(seed, i))) errs++;
      o++;
      if (o == 256) begin o = 0; p = (p + 1 == ring_hi) ? ring_lo : p + 1; end
    end
    return errs;
  endfunction

  task automatic hdr_chk(input string req, input int page, input int st,
                         input int nxt, input int cnt);
    chk({req, " hdr status"}, rd(page * 256 + 0), st);
    chk({req, " hdr next page"}, rd(page * 256 + 1), nxt);
    chk({req, " hdr count lo"}, rd(page * 256 + 2), cnt & 255);
    chk({req, " hdr count hi"}, rd(page * 256 + 3), cnt >> 8);
  endtask

  task automatic t_reset();
    int e;
    chk("R1 mem_we after reset", int'(mem_we), 0);
    chk("R1 pkt_stored after reset", int'(pkt_stored), 0);
    chk("R1 missed after reset", int'(missed), 0);
    chk("R1 ovw_flag after reset", int'(ovw_flag), 0);
    send(5, 3, 8'h01, 1'b1, e);
    chk("R1 default ring start page", rd(16'h0404), int'(pat(3, 0)));
    chk("R1 default header next page", rd(16'h0401), 5);
  endtask

  task automatic t_single();
    int e, k;
    setup(4, 8, 7, 4);
    send(10, 17, 8'h21, 1'b1, e);
    chk("R2 payload bytes", payload_errs(4, 10, 17), 0);
    chk("R2 write count", nlog, 14);
    hdr_chk("R4", 4, 8'h21, 5, 14);
    k = find(16'h0400);
    chk("R4 header byte 0 cycle", (k < 0) ? -1 : log_c[k], e + 1);
    k = find(16'h0403);
    chk("R4 header byte 3 cycle", (k < 0) ? -1 : log_c[k], e + 4);
    chk("R6 stored pulse cycle", stored_cyc, e + 4);
    chk("R6 stored count", n_stored, 1);
    send(3, 40, 8'h01, 1'b1, e);
    chk("R6 next packet at advanced page", rd(16'h0504), int'(pat(40, 0)));
    hdr_chk("R6", 5, 8'h01, 6, 7);
  endtask

  task automatic t_exact();
    int e;
    setup(4, 8, 7, 4);
    send(252, 9, 8'h01, 1'b1, e);
    chk("R5 last byte at offset 255", rd(16'h04FF), int'(pat(9, 251)));
    hdr_chk("R5", 4, 8'h01, 5, 256);
  endtask

  task automatic t_wrap();
    int e;
    setup(4, 8, 6, 7);
    send(300, 55, 8'h01, 1'b1, e);
    chk("R3 byte before wrap", rd(16'h07FF), int'(pat(55, 251)));
    chk("R3 wrapped to start page", rd(16'h0400), int'(pat(55, 252)));
    chk("R3 all payload", payload_errs(7, 300, 55), 0);
    hdr_chk("R3", 7, 8'h01, 5, 304);
  endtask

  task automatic t_overflow();
    int e;
    setup(4, 8, 6, 4);
    send(600, 77, 8'h01, 1'b1, e);
    chk("R7 writes stop at boundary", nlog, 508);
    chk("R7 nothing in boundary page", find(16'h0600), -1);
    chk("R7 no header", find(16'h0400), -1);
    chk("R7 ovw_flag set", int'(ovw_flag), 1);
    chk("R7 missed cycle", missed_cyc, e);
    chk("R7 no stored pulse", n_stored, 0);
    hwr(2'd2, 8'h07);
    chk("R9 ovw cleared by boundary write", int'(ovw_flag), 0);
    send(3, 5, 8'h01, 1'b1, e);
    chk("R7 current page unchanged", rd(16'h0404), int'(pat(5, 0)));
  endtask

  task automatic t_end_refuse();
    int e;
    setup(4, 8, 5, 4);
    send(10, 2, 8'h01, 1'b1, e);
    chk("R8 no header", find(16'h0400), -1);
    chk("R8 missed cycle", missed_cyc, e);
    chk("R8 ovw_flag set", int'(ovw_flag), 1);
    repeat (3) @(negedge clk);
    chk("R9 ovw held without boundary write", int'(ovw_flag), 1);
    chk("R8 no stored pulse", n_stored, 0);
  endtask

  task automatic t_monitor();
    int e;
    setup(4, 8, 7, 4);
    mode_monitor = 1'b1;
    send(6, 8, 8'h01, 1'b1, e);
    mode_monitor = 1'b0;
    chk("R10 no writes in monitor mode", nlog, 0);
    chk("R10 missed cycle", missed_cyc, e);
    chk("R10 no ovw", int'(ovw_flag), 0);
    send(2, 11, 8'h01, 1'b1, e);
    chk("R10 current page unchanged", rd(16'h0404), int'(pat(11, 0)));
  endtask

  task automatic t_bad();
    int e;
    setup(4, 8, 7, 4);
    keep_bad = 1'b0;
    send(5, 30, 8'h02, 1'b0, e);
    chk("R11 bad packet no header", find(16'h0400), -1);
    chk("R11 bad packet no stored", n_stored, 0);
    chk("R11 bad packet no missed", n_missed, 0);
    send(3, 60, 8'h01, 1'b1, e);
    chk("R11 page reused", rd(16'h0404), int'(pat(60, 0)));
    hdr_chk("R11", 4, 8'h01, 5, 7);
    keep_bad = 1'b1;
    send(4, 70, 8'h02, 1'b0, e);
    keep_bad = 1'b0;
    hdr_chk("R11 kept bad", 5, 8'h02, 6, 8);
    chk("R11 kept bad stored", n_stored, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_exact();
    t_wrap();
    t_overflow();
    t_end_refuse();
    t_monitor();
    t_bad();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule